// File: doc/BRIEF.md
# Dual-Chain Logarithmic Shifter

This block is the shift unit of a RISC execute stage. On every clock it accepts one operand, the 5-bit shift-amount field of the instruction, a register value that can supply the amount instead, and the 6-bit R-type function code. One clock later it presents the shifted word. Six operations are supported: logical left, logical right and arithmetic right, each by a constant taken from the instruction field or by a variable taken from a register.

Left and right shifts are built as two separate chains of five fixed-distance multiplexer stages (distances 1, 2, 4, 8 and 16). Each bit of the amount switches one stage in or out, and a last multiplexer picks the chain that matches the decoded direction. The right chain shifts in either zeros or the operand's top bit, depending on the operation. An unrecognised function code yields a zero result and no valid output.

Top module: `shf_top`

## Requirements
- R1: While reset is asserted, and on the first clock after it, `out_valid` is 0 and `result` is all zeros.
- R2: A legal operation presented with `in_valid` high appears on `result` with `out_valid` high on the next rising clock edge, for every amount from 0 to 31.
- R3: Function code 000000 shifts `opnd` left by `shamt_fld`; vacated low bits are 0.
- R4: Function code 000010 shifts `opnd` right by `shamt_fld`; vacated high bits are 0.
- R5: Function code 000011 shifts `opnd` right by `shamt_fld`; vacated high bits copy `opnd` bit 31.
- R6: Function codes 000100, 000110 and 000111 perform the left, logical-right and arithmetic-right shifts with the amount taken from `rs_val` bits 4:0; `rs_val` bits 31:5 and `shamt_fld` have no effect on them.
- R7: A shift amount of zero returns `opnd` unchanged for all six operations.
- R8: Any function code other than the six listed gives `result` = 0 and `out_valid` = 0 on the next edge.
- R9: With `in_valid` low, the next edge gives `result` = 0 and `out_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Inputs carry an operation this cycle |
| funct | input | 6 | R-type function code selecting the operation |
| shamt_fld | input | 5 | Constant shift amount from the instruction |
| rs_val | input | 32 | Register value; bits 4:0 give the variable amount |
| opnd | input | 32 | Word to be shifted |
| out_valid | output | 1 | `result` holds a legal operation's outcome |
| result | output | 32 | Shifted word, registered |

## Verification
Every result of this block is due exactly one rising edge after its inputs are applied, whether the operation is legal, illegal or idle, so there is one latency to track. The bench changes inputs on falling edges, lets its behavioural model capture the expected word and valid flag on the same rising edge as the design, and compares both on the following falling edge, every cycle. Directed passes sweep all 32 amounts for each operation with sign-bit-set and clear operands, fill the unused register bits with noise for the variable forms, and walk illegal codes and idle cycles before a long random run.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [5:0] {
        FN_SLL  = 6'b000000,
        FN_SRL  = 6'b000010,
        FN_SRA  = 6'b000011,
        FN_SLLV = 6'b000100,
        FN_SRLV = 6'b000110,
        FN_SRAV = 6'b000111
    } shf_fn_e;

    typedef struct packed {
        logic legal;
        logic go_left;
        logic arith;
        logic use_reg;
    } shf_ctl_t;

endpackage

// File: rtl/shf_decode.sv
module shf_decode
    import shf_pkg::*;
(
    input  logic [5:0] funct,
    output shf_ctl_t   ctl
);

    always_comb begin
        ctl = '0;
        case (funct)
            FN_SLL:  begin ctl.legal = 1'b1; ctl.go_left = 1'b1; end
            FN_SRL:  begin ctl.legal = 1'b1; end
            FN_SRA:  begin ctl.legal = 1'b1; ctl.arith = 1'b1; end
            FN_SLLV: begin ctl.legal = 1'b1; ctl.go_left = 1'b1; ctl.use_reg = 1'b1; end
            FN_SRLV: begin ctl.legal = 1'b1; ctl.use_reg = 1'b1; end
            FN_SRAV: begin ctl.legal = 1'b1; ctl.arith = 1'b1; ctl.use_reg = 1'b1; end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/shf_chain.sv
module shf_chain #(
    parameter int unsigned W       = 32,
    parameter int unsigned AW      = $clog2(W),
    parameter bit          TO_LEFT = 1'b1
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    input  logic          fill,
    output logic [W-1:0]  dout
);

    logic [W-1:0] stg [0:AW];

    assign stg[0] = din;

    for (genvar k = 0; k < AW; k++) begin : g_stage
        localparam int unsigned DIST = 1 << k;
        if (TO_LEFT) begin : g_left
            assign stg[k+1] = amt[k] ? {stg[k][W-1-DIST:0], {DIST{fill}}} : stg[k];
        end else begin : g_right
            assign stg[k+1] = amt[k] ? {{DIST{fill}}, stg[k][W-1:DIST]} : stg[k];
        end
    end

    assign dout = stg[AW];

endmodule

// File: rtl/shf_top.sv
module shf_top
    import shf_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned AMT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [5:0]        funct,
    input  logic [AMT_W-1:0]  shamt_fld,
    input  logic [DATA_W-1:0] rs_val,
    input  logic [DATA_W-1:0] opnd,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);

    localparam int unsigned MSB = DATA_W - 1;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
    } shf_st_t;

    shf_st_t  st_d, st_q;
    shf_ctl_t ctl;

    logic [AMT_W-1:0]  amt;
    logic              rfill;
    logic [DATA_W-1:0] left_out;
    logic [DATA_W-1:0] right_out;
    logic              unused_rs_hi;

    assign unused_rs_hi = ^rs_val[DATA_W-1:AMT_W];

    shf_decode u_dec (
        .funct (funct),
        .ctl   (ctl)
    );

    assign amt   = ctl.use_reg ? rs_val[AMT_W-1:0] : shamt_fld;
    assign rfill = ctl.arith & opnd[MSB];

    shf_chain #(.W(DATA_W), .AW(AMT_W), .TO_LEFT(1'b1)) u_left (
        .din  (opnd),
        .amt  (amt),
        .fill (1'b0),
        .dout (left_out)
    );

    shf_chain #(.W(DATA_W), .AW(AMT_W), .TO_LEFT(1'b0)) u_right (
        .din  (opnd),
        .amt  (amt),
        .fill (rfill),
        .dout (right_out)
    );

    always_comb begin
        st_d = '0;
        if (in_valid && ctl.legal) begin
            st_d.vld = 1'b1;
            st_d.res = ctl.go_left ? left_out : right_out;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;

    // R8 and R9: no valid output means a zero word
    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (result == '0));

    assert_legal_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ctl.legal) |=> out_valid);

    assert_zero_amt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ctl.legal && amt == '0) |=> (result == $past(opnd)));

    assert_sll_low_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ctl.legal && ctl.go_left && amt != '0) |=> !result[0]);

    assert_srl_top_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ctl.legal && !ctl.go_left && !ctl.arith && amt != '0) |=> !result[MSB]);

    assert_sra_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ctl.legal && !ctl.go_left && ctl.arith) |=> (result[MSB] == $past(opnd[MSB])));

endmodule

// File: tb/sim_shf_top.sv
module sim_shf_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [5:0]  funct = '0;
    logic [4:0]  shamt_fld = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] opnd = '0;
    logic        out_valid;
    logic [31:0] result;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic        exp_vld = 1'b0;
    logic [31:0] exp_res = '0;
    string       exp_tag = "R1";

    shf_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .funct     (funct),
        .shamt_fld (shamt_fld),
        .rs_val    (rs_val),
        .opnd      (opnd),
        .out_valid (out_valid),
        .result    (result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference, updated on the same edge as the design
    always @(posedge clk) begin
        int amt;
        logic [31:0] r;
        bit ok;
        if (!rst_n) begin
            exp_vld <= 1'b0; exp_res <= '0; exp_tag <= "R1";
        end else begin
            ok = 1'b1;
            amt = (funct[2]) ? int'(rs_val[4:0]) : int'(shamt_fld);
            case (funct)
                6'b000000, 6'b000100: r = opnd << amt;
                6'b000010, 6'b000110: r = opnd >> amt;
                6'b000011, 6'b000111: r = $unsigned($signed(opnd) >>> amt);
                default: begin r = '0; ok = 1'b0; end
            endcase
            if (!in_valid) begin
                exp_vld <= 1'b0; exp_res <= '0; exp_tag <= "R9";
            end else if (!ok) begin
                exp_vld <= 1'b0; exp_res <= '0; exp_tag <= "R8";
            end else begin
                exp_vld <= 1'b1; exp_res <= r;
                if (amt == 0)          exp_tag <= "R7";
                else if (funct[2])     exp_tag <= "R6";
                else if (funct == 6'b000000) exp_tag <= "R3";
                else if (funct == 6'b000010) exp_tag <= "R4";
                else                   exp_tag <= "R5";
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            cycles++;
            total++;
            if (out_valid !== exp_vld || result !== exp_res) begin
                bad++;
                $display("FAIL R2 %s: actual vld=%0b res=%08h expected vld=%0b res=%08h",
                         exp_tag, out_valid, result, exp_vld, exp_res);
            end
            if (cycles > WATCHDOG) begin
                bad++;
                total++;
                $display("FAIL R2 watchdog: actual cycles=%0d expected below %0d", cycles, WATCHDOG);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    task automatic step(input logic v, input logic [5:0] f, input logic [4:0] sh,
                        input logic [31:0] rs, input logic [31:0] op);
        in_valid = v; funct = f; shamt_fld = sh; rs_val = rs; opnd = op;
        @(negedge clk);
    endtask

    initial begin
        logic [5:0] fcodes [6];
        logic [5:0] badf [5];
        fcodes = '{6'b000000, 6'b000010, 6'b000011, 6'b000100, 6'b000110, 6'b000111};
        badf   = '{6'b000001, 6'b000101, 6'b001000, 6'b100000, 6'b111111};

        // R1: reset state, including garbage inputs during reset
        @(negedge clk);
        step(1'b1, 6'b000000, 5'd3, 32'hFFFF_FFFF, 32'h1234_5678);
        step(1'b1, 6'b000011, 5'd7, 32'h0, 32'h8000_0000);
        rst_n = 1'b1;
        step(1'b0, 6'b000000, 5'd0, 32'h0, 32'h0);

        // R3 R4 R5 R7: every constant amount on sign-set and sign-clear words
        for (int i = 0; i < 3; i++)
            for (int a = 0; a < 32; a++) begin
                step(1'b1, fcodes[i], a[4:0], 32'hDEAD_BEE0, 32'h8765_4321);
                step(1'b1, fcodes[i], a[4:0], 32'hFFFF_FFFF, 32'h5A5A_A5A5);
            end

        // R6: register amount, noisy upper rs bits and a misleading shamt field
        for (int i = 3; i < 6; i++)
            for (int a = 0; a < 32; a++) begin
                step(1'b1, fcodes[i], 5'(31 - a), {27'h5ABCDEF, a[4:0]}, 32'hF00F_0FF1);
                step(1'b1, fcodes[i], 5'd0, {27'h7FFFFFF, a[4:0]}, 32'h0F0F_F0F0);
            end

        // R8: illegal codes between legal ones
        for (int i = 0; i < 5; i++) begin
            step(1'b1, badf[i], 5'd4, 32'h3, 32'hCAFE_F00D);
            step(1'b1, 6'b000010, 5'd4, 32'h3, 32'hCAFE_F00D);
        end

        // R9: idle cycles with live-looking inputs
        step(1'b0, 6'b000011, 5'd1, 32'h1, 32'h8000_0001);
        step(1'b0, 6'b000100, 5'd9, 32'h9, 32'hFFFF_FFFF);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [5:0] f;
            f = ($urandom_range(0, 9) == 0) ? 6'($urandom) : fcodes[$urandom_range(0, 5)];
            step($urandom_range(0, 7) != 0, f, 5'($urandom), $urandom, $urandom);
        end

        step(1'b0, 6'b0, 5'd0, 32'h0, 32'h0);
        step(1'b0, 6'b0, 5'd0, 32'h0, 32'h0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule